// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns a virtual address presented by a DMA master into a physical address. It does so by reading one 64-bit translation entry from a table held in main memory. A request arrives on a valid/ready handshake. At acceptance the unit captures the address together with the control word and the table base, which come from a companion register bank. From the captured values it computes where the entry lives and issues a single read on its memory-request port. When the read data returns, the unit decodes the entry and offers the physical address, a permission code and a fault flag on a response handshake.

The walk has two granules, 8 KB and 64 KB, chosen by a mode bit. The table size is given by a 3-bit field. Together these decide how many virtual-address bits form the table index. Each entry carries its own valid bit, write bit and page-size bit, so the page size of an entry can differ from the walk granule.

When translation is disabled, the address passes through unchanged with full permission and no memory access. Only one walk is in flight at a time, and the response is held until it is taken.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_valid` and `rsp_valid` are 0.
- R2: With control bit 0 clear, a request is answered with `rsp_paddr` equal to the request address, permission read-write (2'b11) and no fault. No memory read is issued.
- R3: With control bits 0 set, 2 clear (8 KB walk) and size s in control bits 18:16, the read address is the table base plus 8 times the index. The index is formed from virtual-address bits 22+s down to 13, for every s from 0 to 7.
- R4: With control bits 0 and 2 set (64 KB walk), the read address is the table base plus 8 times the index. The index is formed from virtual-address bits 25+s down to 16, for s from 0 to 5.
- R5: In the 64 KB walk, size codes 6 and 7 give a fault with permission 2'b00 and address 0. No memory read is issued.
- R6: The entry is stored big-endian. The byte at the lowest address is entry bits 63:56. On `mem_rsp_data`, the byte at read address + k sits in bits 8k+7:8k.
- R7: An entry whose bit 63 is clear gives a fault with permission 2'b00 and address 0.
- R8: A valid entry with bit 1 set gives permission read-write (2'b11). A valid entry with bit 1 clear gives read-only (2'b01). The code 2'b10 never appears.
- R9: A valid entry with bit 61 clear maps an 8 KB page. The physical address is entry bits 40:13 above virtual-address bits 12:0, with all higher bits zero.
- R10: A valid entry with bit 61 set maps a 64 KB page. The physical address is entry bits 40:16 above virtual-address bits 15:0, with all higher bits zero.
- R11: A memory response with `mem_rsp_err` high gives a fault with permission 2'b00 and address 0, whatever the data.
- R12: The unit handles one walk at a time. `req_ready` stays low from acceptance until the response is taken. `mem_rd_addr` is held while `mem_rd_valid` waits for `mem_rd_ready`. The response is held while `rsp_valid` waits for `rsp_ready`.
- R13: Control and base inputs are sampled only when a request is accepted. Changes to them during a walk do not alter its read address or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | ADDR_W | Virtual address to translate |
| cfg_ctrl | input | CTRL_W | Control word: enable, walk mode, table size |
| cfg_base | input | ADDR_W | Table base address |
| mem_rd_valid | output | 1 | Entry read request present |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | ADDR_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | ENTRY_W | Entry bytes in address order by lane |
| mem_rsp_err | input | 1 | Read ended in error |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_fault | output | 1 | Translation fault |

## Verification
Every table size is swept in both walk modes with a virtual address whose bits are set well above and below the index field. A read address that is wrong at either end of the field therefore shows up at once. The entries used have distinct bytes, so a swapped lane or a misplaced physical slice cannot hide. Some entries also mark the page size opposite to the walk granule, which separates the walk granule from the entry's own page size. Faults are covered by invalid entries, bus errors and the two unsupported 64 KB sizes. These are mixed with stalls on both handshakes and with control and base values flipped mid-walk, which shows that the captured copies, not the live inputs, drive each walk.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

  // Access rights returned with each translation
  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  // Walk sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } walk_st_e;

  typedef struct packed {
    perm_e perm;
    logic  fault;
  } xlate_flags_t;

endpackage

// File: rtl/xlate_offset.sv
// Table byte offset from the virtual address, walk mode and size code
module xlate_offset #(
  parameter int ADDR_W         = 64,
  parameter int SIZE_W         = 3,
  parameter int IDX_BASE_W     = 10,
  parameter int LO_SMALL       = 13,
  parameter int LO_LARGE       = 16,
  parameter int MAX_LARGE_SIZE = 5,
  parameter int ENTRY_SHIFT    = 3
) (
  input  logic [ADDR_W-1:0] va,
  input  logic              walk_large,
  input  logic [SIZE_W-1:0] tbl_size,
  output logic [ADDR_W-1:0] byte_off,
  output logic              size_bad
);

  localparam logic [SIZE_W-1:0] LARGE_LIMIT = SIZE_W'(MAX_LARGE_SIZE);

  logic [ADDR_W-1:0] shifted;
  logic [ADDR_W-1:0] keep;
  int                idx_w;

  always_comb begin
    shifted = walk_large ? (va >> LO_LARGE) : (va >> LO_SMALL);
    idx_w   = IDX_BASE_W + int'(tbl_size);
    for (int i = 0; i < ADDR_W; i++) begin
      keep[i] = (i < idx_w);
    end
    byte_off = (shifted & keep) << ENTRY_SHIFT;
    size_bad = walk_large && (tbl_size > LARGE_LIMIT);
  end

endmodule

// File: rtl/xlate_entry_decode.sv
// Reorders entry lanes and forms the physical address and rights
module xlate_entry_decode #(
  parameter int ADDR_W     = 64,
  parameter int ENTRY_W    = 64,
  parameter int VALID_BIT  = 63,
  parameter int LARGE_BIT  = 61,
  parameter int WRITE_BIT  = 1,
  parameter int PHYS_HI    = 40,
  parameter int SMALL_PG_W = 13,
  parameter int LARGE_PG_W = 16
) (
  input  logic [ENTRY_W-1:0] lanes,
  input  logic               bus_err,
  input  logic [ADDR_W-1:0]  va,
  output logic [ADDR_W-1:0]  paddr,
  output dma_xlate_pkg::xlate_flags_t flags
);
  import dma_xlate_pkg::*;

  localparam int NBYTES = ENTRY_W / 8;
  localparam logic [ADDR_W-1:0] ONE_A   = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] HI_KEEP = {ADDR_W{1'b1}} >> (ADDR_W - 1 - PHYS_HI);
  localparam logic [ADDR_W-1:0] SMALL_M = (ONE_A << SMALL_PG_W) - ONE_A;
  localparam logic [ADDR_W-1:0] LARGE_M = (ONE_A << LARGE_PG_W) - ONE_A;

  logic [ENTRY_W-1:0] entry;

  // Lowest-address lane becomes the most significant byte
  for (genvar k = 0; k < NBYTES; k++) begin : g_swap
    assign entry[ENTRY_W-1-8*k -: 8] = lanes[8*k +: 8];
  end

  logic [ADDR_W-1:0] ent_a;
  logic [ADDR_W-1:0] off_mask;
  logic              bad;

  always_comb begin
    ent_a    = ADDR_W'(entry);
    off_mask = entry[LARGE_BIT] ? LARGE_M : SMALL_M;
    bad      = bus_err || !entry[VALID_BIT];
    if (bad) begin
      paddr       = '0;
      flags.perm  = PERM_NONE;
      flags.fault = 1'b1;
    end else begin
      paddr       = (ent_a & HI_KEEP & ~off_mask) | (va & off_mask);
      flags.perm  = entry[WRITE_BIT] ? PERM_RW : PERM_RO;
      flags.fault = 1'b0;
    end
  end

endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit #(
  parameter int ADDR_W         = 64,
  parameter int ENTRY_W        = 64,
  parameter int CTRL_W         = 64,
  parameter int EN_BIT         = 0,
  parameter int MODE_BIT       = 2,
  parameter int SIZE_LSB       = 16,
  parameter int SIZE_W         = 3,
  parameter int IDX_BASE_W     = 10,
  parameter int LO_SMALL       = 13,
  parameter int LO_LARGE       = 16,
  parameter int MAX_LARGE_SIZE = 5,
  parameter int VALID_BIT      = 63,
  parameter int LARGE_BIT      = 61,
  parameter int WRITE_BIT      = 1,
  parameter int PHYS_HI        = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [CTRL_W-1:0]   cfg_ctrl,
  input  logic [ADDR_W-1:0]   cfg_base,
  output logic                mem_rd_valid,
  input  logic                mem_rd_ready,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic                mem_rsp_valid,
  input  logic [ENTRY_W-1:0]  mem_rsp_data,
  input  logic                mem_rsp_err,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic [1:0]          rsp_perm,
  output logic                rsp_fault
);
  import dma_xlate_pkg::*;

  localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);

  walk_st_e          state_q;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [ADDR_W-1:0] paddr_q;
  xlate_flags_t      flags_q;

  // Index arithmetic on the live inputs, used only at acceptance
  logic [ADDR_W-1:0] byte_off;
  logic              size_bad;

  xlate_offset #(
    .ADDR_W        (ADDR_W),
    .SIZE_W        (SIZE_W),
    .IDX_BASE_W    (IDX_BASE_W),
    .LO_SMALL      (LO_SMALL),
    .LO_LARGE      (LO_LARGE),
    .MAX_LARGE_SIZE(MAX_LARGE_SIZE),
    .ENTRY_SHIFT   (ENTRY_SHIFT)
  ) u_offset (
    .va        (req_vaddr),
    .walk_large(cfg_ctrl[MODE_BIT]),
    .tbl_size  (cfg_ctrl[SIZE_LSB +: SIZE_W]),
    .byte_off  (byte_off),
    .size_bad  (size_bad)
  );

  // Entry decode works on the captured address
  logic [ADDR_W-1:0] dec_paddr;
  xlate_flags_t      dec_flags;

  xlate_entry_decode #(
    .ADDR_W    (ADDR_W),
    .ENTRY_W   (ENTRY_W),
    .VALID_BIT (VALID_BIT),
    .LARGE_BIT (LARGE_BIT),
    .WRITE_BIT (WRITE_BIT),
    .PHYS_HI   (PHYS_HI),
    .SMALL_PG_W(LO_SMALL),
    .LARGE_PG_W(LO_LARGE)
  ) u_decode (
    .lanes  (mem_rsp_data),
    .bus_err(mem_rsp_err),
    .va     (va_q),
    .paddr  (dec_paddr),
    .flags  (dec_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      va_q          <= '0;
      rd_addr_q     <= '0;
      paddr_q       <= '0;
      flags_q.perm  <= PERM_NONE;
      flags_q.fault <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q <= req_vaddr;
            if (!cfg_ctrl[EN_BIT]) begin
              paddr_q       <= req_vaddr;
              flags_q.perm  <= PERM_RW;
              flags_q.fault <= 1'b0;
              state_q       <= ST_RESP;
            end else if (size_bad) begin
              paddr_q       <= '0;
              flags_q.perm  <= PERM_NONE;
              flags_q.fault <= 1'b1;
              state_q       <= ST_RESP;
            end else begin
              rd_addr_q <= cfg_base + byte_off;
              state_q   <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (mem_rd_ready) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            paddr_q <= dec_paddr;
            flags_q <= dec_flags;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_FETCH);
  assign mem_rd_addr  = rd_addr_q;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_perm     = flags_q.perm;
  assign rsp_fault    = flags_q.fault;

endmodule

// File: rtl/dma_xlate_unit_chk.sv
module dma_xlate_unit_chk #(
  parameter int ADDR_W         = 64,
  parameter int CTRL_W         = 64,
  parameter int EN_BIT         = 0,
  parameter int MODE_BIT       = 2,
  parameter int SIZE_LSB       = 16,
  parameter int SIZE_W         = 3,
  parameter int MAX_LARGE_SIZE = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [CTRL_W-1:0] cfg_ctrl,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_perm,
  input logic              rsp_fault
);

  logic accept;
  assign accept = req_valid && req_ready;

  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
                                && $stable(rsp_perm) && $stable(rsp_fault));

  // R7
  fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_perm == 2'b00 && rsp_paddr == '0);

  // R8
  perm_code_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_perm != 2'b10);

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !cfg_ctrl[EN_BIT] |=> rsp_valid && !rsp_fault
                                   && rsp_perm == 2'b11 && rsp_paddr == $past(req_vaddr));

  // R5
  size_fault_chk: assert property (@(posedge clk) disable iff (rst)
    accept && cfg_ctrl[EN_BIT] && cfg_ctrl[MODE_BIT]
      && (cfg_ctrl[SIZE_LSB +: SIZE_W] > SIZE_W'(MAX_LARGE_SIZE))
      |=> rsp_valid && rsp_fault && !mem_rd_valid);

endmodule

bind dma_xlate_unit dma_xlate_unit_chk #(
  .ADDR_W        (ADDR_W),
  .CTRL_W        (CTRL_W),
  .EN_BIT        (EN_BIT),
  .MODE_BIT      (MODE_BIT),
  .SIZE_LSB      (SIZE_LSB),
  .SIZE_W        (SIZE_W),
  .MAX_LARGE_SIZE(MAX_LARGE_SIZE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .cfg_ctrl    (cfg_ctrl),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr (mem_rd_addr),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_paddr   (rsp_paddr),
  .rsp_perm    (rsp_perm),
  .rsp_fault   (rsp_fault)
);

// File: tb/dma_xlate_unit_tb.sv
`timescale 1ns/1ps
module dma_xlate_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [63:0] cfg_ctrl = '0;
  logic [63:0] cfg_base = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_paddr;
  logic [1:0]  rsp_perm;
  logic        rsp_fault;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit busy = 0;     // model: a walk is in flight
  bit rd_open = 0;  // model: an entry read may be pending

  always #2 clk = ~clk;  // 250 MHz

  dma_xlate_unit u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .cfg_ctrl(cfg_ctrl), .cfg_base(cfg_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the handshake model, 1 ns after each edge
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!rst) begin
      chk("R12 req_ready vs model", 64'(req_ready), 64'(!busy));
      if (!rd_open) chk("R12 no stray read", 64'(mem_rd_valid), 64'd0);
    end
  end

  // Entry table address, built bit by bit from the index field limits
  function automatic logic [63:0] exp_rd_addr(input logic [63:0] ctrl, input logic [63:0] base,
                                              input logic [63:0] va);
    int s = int'(ctrl[18:16]);
    int lo = ctrl[2] ? 16 : 13;
    int hi = ctrl[2] ? 25 + s : 22 + s;
    logic [63:0] idx = '0;
    for (int i = lo; i <= hi; i++) idx[i-lo] = va[i];
    return base + idx * 64'd8;
  endfunction

  // Memory lanes: byte at address+k on bits 8k+7:8k, big-endian entry
  function automatic logic [63:0] to_lanes(input logic [63:0] e);
    logic [63:0] l;
    for (int k = 0; k < 8; k++) l[8*k +: 8] = e[63-8*k -: 8];
    return l;
  endfunction

  task automatic walk(input string tag, input logic [63:0] ctrl, input logic [63:0] base,
                      input logic [63:0] va, input logic [63:0] e, input bit err,
                      input int stall, input int lat, input int hold);
    logic [63:0] xp; logic [1:0] xperm; bit xfault; bit need_rd;
    int s = int'(ctrl[18:16]);
    need_rd = ctrl[0] && !(ctrl[2] && s > 5);
    if (!ctrl[0]) begin xp = va; xperm = 2'b11; xfault = 0; end
    else if (!need_rd || err || !e[63]) begin xp = '0; xperm = 2'b00; xfault = 1; end
    else begin
      xperm = e[1] ? 2'b11 : 2'b01; xfault = 0;
      if (e[61]) xp = {23'd0, e[40:16], va[15:0]};
      else       xp = {23'd0, e[40:13], va[12:0]};
    end
    @(negedge clk);
    req_valid = 1; req_vaddr = va; cfg_ctrl = ctrl; cfg_base = base;
    busy = 1; rd_open = need_rd;
    @(negedge clk);
    req_valid = 0;
    // R13: scramble configuration once the walk is under way
    cfg_ctrl = ~ctrl; cfg_base = ~base;
    if (need_rd) begin
      chk({tag, " R3/R4 read valid"}, 64'(mem_rd_valid), 64'd1);
      chk({tag, " R3/R4 R13 read addr"}, mem_rd_addr, exp_rd_addr(ctrl, base, va));
      repeat (stall) @(negedge clk);
      chk({tag, " R12 read held"}, mem_rd_addr, exp_rd_addr(ctrl, base, va));
      mem_rd_ready = 1; rd_open = 1;
      @(negedge clk);
      mem_rd_ready = 0; rd_open = 0;
      repeat (lat) @(negedge clk);
      chk({tag, " R12 no early rsp"}, 64'(rsp_valid), 64'd0);
      mem_rsp_valid = 1; mem_rsp_data = to_lanes(e); mem_rsp_err = err;
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = '0; mem_rsp_err = 0;
    end
    repeat (hold + 1) begin
      chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      chk({tag, " R9/R10 paddr"}, rsp_paddr, xp);
      chk({tag, " R8 perm"}, 64'(rsp_perm), 64'(xperm));
      chk({tag, " R7/R11 fault"}, 64'(rsp_fault), 64'(xfault));
      if (hold > 0) @(negedge clk);
      hold--;
    end
    rsp_ready = 1; busy = 0;
    @(negedge clk);
    rsp_ready = 0;
    chk({tag, " R12 released"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin : watchdog
    wait (cycles >= 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] va_pat = 64'hA5C3_F0F0_FFFF_E6B5;
    logic [63:0] e8  = 64'h8013_57_9B_DF_24_6A_02;  // valid, 8K page, W
    logic [63:0] e64 = 64'hA0C4_1E_2D_3C_4B_5A_69;  // valid, 64K page, RO
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);

    // R2 bypass, with other control bits set
    walk("R2 bypass", 64'h0, 64'h1000, va_pat, 64'h0, 0, 0, 0, 0);
    walk("R2 bypass bits", 64'h0007_0004, 64'h2000, 64'h1234_5678_9ABC_DEF1, 64'h0, 0, 0, 0, 1);

    // R3 8K walk, every size, R6 byte order, R9 page, R8 write
    for (int s = 0; s < 8; s++)
      walk("R3 R6 R9 8K walk", (64'(s) << 16) | 64'h1, 64'h0000_0040_0000_0000,
           va_pat, e8, 0, s % 3, 1, s % 2);

    // R4 64K walk, sizes 0..5, R10 page and read-only
    for (int s = 0; s < 6; s++)
      walk("R4 R10 64K walk", (64'(s) << 16) | 64'h5, 64'h0000_0001_2345_6000,
           va_pat, e64, 0, 1, s % 2, 0);

    // R5 unsupported 64K sizes
    walk("R5 size6", 64'h0006_0005, 64'h8000, va_pat, e8, 0, 0, 0, 0);
    walk("R5 size7", 64'h0007_0005, 64'h8000, va_pat, e8, 0, 0, 0, 2);

    // R10 64K page under an 8K walk; R9 8K page under a 64K walk
    walk("R10 large page 8K walk", 64'h0002_0001, 64'h4000, va_pat, e64, 0, 0, 0, 0);
    walk("R9 small page 64K walk", 64'h0003_0005, 64'h4000, va_pat, e8, 0, 0, 2, 0);

    // R7 invalid entry, R11 bus error, R8 read-only
    walk("R7 invalid", 64'h0001, 64'h9000, va_pat, e8 & ~(64'h1 << 63), 0, 0, 0, 1);
    walk("R11 bus err", 64'h0001, 64'h9000, va_pat, e8, 1, 2, 1, 0);
    walk("R8 read only", 64'h0001, 64'h9000, va_pat, e8 & ~64'h2, 0, 0, 0, 0);
    walk("R8 read write 64K", 64'h0001, 64'h9000, 64'h0, e64 | 64'h2, 0, 0, 0, 0);

    // R12 long stalls on both handshakes
    walk("R12 stalls", 64'h0004_0001, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, e8, 0, 5, 4, 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule